// File: doc/BRIEF.md
# Priority Sequence Scheduler

This block chooses which of up to 64 hardware execution contexts, called sequences, issues the next instruction. Every sequence owns one runnable flag. Peripherals and instructions raise or lower these flags at any cycle. At each instruction boundary the block selects the runnable sequence with the smallest number, unless the instruction that just finished carries its hold bit.

The program counter of the sequence being left is saved in the low bits of that sequence's own entry in a 64-entry index store. The program counter of the sequence being entered is read back from its entry and presented with a one-cycle switch pulse. If the entry's top bit is set and trapping is enabled, the block raises the flag of the trap sequence (number 34, octal 42) and pulses a trap request. A start command resets the scheduling state and begins sequence 0 at a supplied address.

Top module: `seq_priority_sched`

## Requirements
- R1: After reset `cur_seq` is 0, every flag is clear, `switch_pulse` and `trap_req` are low, and every index entry reads 0.
- R2: On a cycle with `boundary` high, `hold` low and `start` low, the lowest-numbered sequence whose flag is set after this cycle's updates becomes current. If no flag is set, the current sequence stays.
- R3: A boundary with `hold` high never changes `cur_seq`. A `dismiss` given together with `hold` has no effect.
- R4: Bit n of `raise_vec` sets flag n and bit n of `lower_vec` clears it, in any cycle. When both arrive in the same cycle, the flag ends up set.
- R5: `dismiss` at a boundary without hold clears the current sequence's flag. If no other flag is set, the current sequence stays selected with its flag low.
- R6: `stall` at a boundary clears the current sequence's flag whether or not `hold` is set. The sequence runs again only after its flag is raised.
- R7: On a switch, bits 16:0 of the outgoing sequence's index entry take `cur_pc` and bit 17 is kept. `resume_pc` takes bits 16:0 of the incoming sequence's entry as it was before this edge.
- R8: `switch_pulse` is high for the single cycle after each edge at which the current sequence changed or a start was taken.
- R9: When the incoming sequence's index bit 17 is set and `trap_en` is high, flag 34 is set at the switch edge and `trap_req` pulses together with `switch_pulse`.
- R10: `start` overrides every other input. It clears all flags, makes sequence 0 current, loads `resume_pc` with `start_pc` and pulses `switch_pulse`. No program counter is saved.
- R11: `idx_we` writes `idx_wdata` to entry `idx_wsel`, except when that entry is the one being saved at a switch in the same cycle. `rd_data` always shows entry `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boundary | input | 1 | Instruction boundary strobe |
| hold | input | 1 | Hold bit of the instruction just completed |
| dismiss | input | 1 | Current sequence yields |
| stall | input | 1 | Current sequence's peripheral not ready |
| raise_vec | input | 64 | Per-sequence flag set requests |
| lower_vec | input | 64 | Per-sequence flag clear requests |
| start | input | 1 | Start command |
| start_pc | input | 17 | Start address for sequence 0 |
| cur_pc | input | 17 | Program counter of the running sequence |
| trap_en | input | 1 | Enables trap on entry |
| idx_we | input | 1 | Index entry write enable |
| idx_wsel | input | 6 | Index entry written |
| idx_wdata | input | 18 | Index write data |
| rd_sel | input | 6 | Index entry read |
| rd_data | output | 18 | Index entry read data |
| cur_seq | output | 6 | Current sequence number |
| switch_pulse | output | 1 | One-cycle pulse on sequence entry |
| resume_pc | output | 17 | Program counter of the entered sequence |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The flag raise and flag lower for one sequence can land in the same cycle. So can the save of the outgoing program counter at a switch and an explicit index write to that same entry. The bench drives both collisions on purpose and also lets random vectors produce them. The winner is then read at the ports: a later boundary shows whether the flag survived, and the read port shows which value reached the index entry. A bench model applies the stated precedence and predicts every output cycle by cycle.

// File: rtl/seq_priority_sched.sv
module seq_priority_sched #(
  parameter int NSEQ     = 64,
  parameter int PCW      = 17,
  parameter int TRAP_SEQ = 34
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     boundary,
  input  logic                     hold,
  input  logic                     dismiss,
  input  logic                     stall,
  input  logic [NSEQ-1:0]          raise_vec,
  input  logic [NSEQ-1:0]          lower_vec,
  input  logic                     start,
  input  logic [PCW-1:0]           start_pc,
  input  logic [PCW-1:0]           cur_pc,
  input  logic                     trap_en,
  input  logic                     idx_we,
  input  logic [$clog2(NSEQ)-1:0]  idx_wsel,
  input  logic [PCW:0]             idx_wdata,
  input  logic [$clog2(NSEQ)-1:0]  rd_sel,
  output logic [PCW:0]             rd_data,
  output logic [$clog2(NSEQ)-1:0]  cur_seq,
  output logic                     switch_pulse,
  output logic [PCW-1:0]           resume_pc,
  output logic                     trap_req
);
  localparam int SW  = $clog2(NSEQ);
  localparam int IXW = PCW + 1;

  logic [NSEQ-1:0] flags, eff, own, trap_bit;
  logic [IXW-1:0]  ixr [NSEQ];
  logic [SW-1:0]   pick;
  logic            suspend, any, sw, trap_hit;

  assign suspend  = boundary && ((dismiss && !hold) || stall);
  assign own      = suspend ? (NSEQ'(1) << cur_seq) : '0;
  assign eff      = (flags & ~lower_vec & ~own) | raise_vec;
  assign any      = |eff;

  always_comb begin
    pick = '0;
    for (int i = NSEQ - 1; i >= 0; i--)
      if (eff[i]) pick = SW'(i);
  end

  assign sw       = !start && boundary && !hold && any && (pick != cur_seq);
  assign trap_hit = sw && trap_en && ixr[pick][IXW-1];
  assign trap_bit = trap_hit ? (NSEQ'(1) << TRAP_SEQ) : '0;
  assign rd_data  = ixr[rd_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags        <= '0;
      cur_seq      <= '0;
      resume_pc    <= '0;
      switch_pulse <= 1'b0;
      trap_req     <= 1'b0;
    end else if (start) begin
      flags        <= '0;
      cur_seq      <= '0;
      resume_pc    <= start_pc;
      switch_pulse <= 1'b1;
      trap_req     <= 1'b0;
    end else begin
      flags        <= eff | trap_bit;
      switch_pulse <= sw;
      trap_req     <= trap_hit;
      if (sw) begin
        cur_seq   <= pick;
        resume_pc <= ixr[pick][PCW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEQ; i++) ixr[i] <= '0;
    end else begin
      if (idx_we && !(sw && idx_wsel == cur_seq)) ixr[idx_wsel] <= idx_wdata;
      if (sw) ixr[cur_seq][PCW-1:0] <= cur_pc;
    end
  end

  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && hold && !start) |=> (cur_seq == $past(cur_seq)));

  p_pick_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !hold && !start && any) |=>
      ((($past(eff) & ((NSEQ'(1) << cur_seq) - NSEQ'(1))) == '0) &&
       (|($past(eff) & (NSEQ'(1) << cur_seq)))));

  p_raise_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ((flags & $past(raise_vec)) == $past(raise_vec)));

  p_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cur_seq == '0 && flags == '0 && switch_pulse &&
               resume_pc == $past(start_pc)));

  p_trap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (flags[TRAP_SEQ] && switch_pulse));

  p_switch_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !start) |=> (switch_pulse == (cur_seq != $past(cur_seq))));
endmodule

// File: tb/seq_priority_sched_test.sv
module seq_priority_sched_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        boundary = 0, hold = 0, dismiss = 0, stall = 0, start = 0;
  logic [63:0] raise_vec = '0, lower_vec = '0;
  logic [16:0] start_pc = '0, cur_pc = '0, resume_pc;
  logic        trap_en = 0, idx_we = 0;
  logic [5:0]  idx_wsel = '0, rd_sel = '0, cur_seq;
  logic [17:0] idx_wdata = '0, rd_data;
  logic        switch_pulse, trap_req;

  int checks = 0, failures = 0;

  logic [63:0] m_flags = '0;
  int          m_cur = 0;
  logic [17:0] m_ix [64];
  logic [16:0] m_rpc = '0;
  bit          m_sw = 0, m_trap = 0;

  always #10 clk = ~clk;

  seq_priority_sched uut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .hold(hold), .dismiss(dismiss),
    .stall(stall), .raise_vec(raise_vec), .lower_vec(lower_vec), .start(start),
    .start_pc(start_pc), .cur_pc(cur_pc), .trap_en(trap_en), .idx_we(idx_we),
    .idx_wsel(idx_wsel), .idx_wdata(idx_wdata), .rd_sel(rd_sel), .rd_data(rd_data),
    .cur_seq(cur_seq), .switch_pulse(switch_pulse), .resume_pc(resume_pc),
    .trap_req(trap_req));

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowest(logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic idle();
    boundary = 0; hold = 0; dismiss = 0; stall = 0; start = 0;
    raise_vec = '0; lower_vec = '0; idx_we = 0;
  endtask

  task automatic step();
    logic [63:0] own, eff;
    logic [17:0] old_in;
    int p;
    bit sw, tr;
    own = (boundary && ((dismiss && !hold) || stall)) ? (64'd1 << m_cur) : '0;
    eff = (m_flags & ~lower_vec & ~own) | raise_vec;
    p = lowest(eff);
    sw = !start && boundary && !hold && p >= 0 && p != m_cur;
    old_in = (p >= 0) ? m_ix[p] : '0;
    tr = sw && trap_en && old_in[17];
    if (idx_we && !(sw && int'(idx_wsel) == m_cur)) m_ix[idx_wsel] = idx_wdata;
    if (start) begin
      m_flags = '0; m_cur = 0; m_rpc = start_pc; m_sw = 1; m_trap = 0;
    end else begin
      if (sw) m_ix[m_cur][16:0] = cur_pc;
      m_flags = eff | (tr ? (64'd1 << 34) : '0);
      m_sw = sw; m_trap = tr;
      if (sw) begin m_cur = p; m_rpc = old_in[16:0]; end
    end
    @(posedge clk);
    @(negedge clk);
    check(cur_seq == 6'(m_cur), "R2 cur_seq", cur_seq, m_cur);
    check(switch_pulse == m_sw, "R8 switch_pulse", switch_pulse, m_sw);
    check(resume_pc == m_rpc, "R7 resume_pc", resume_pc, m_rpc);
    check(trap_req == m_trap, "R9 trap_req", trap_req, m_trap);
    check(rd_data == m_ix[rd_sel], "R11 rd_data", rd_data, m_ix[rd_sel]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) m_ix[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cur_seq == 0, "R1 cur_seq", cur_seq, 0);
    check(!switch_pulse && !trap_req, "R1 pulses", {switch_pulse, trap_req}, 0);
    rd_sel = 6'd40; #1;
    check(rd_data == 0, "R1 index entry", rd_data, 0);

    // R2 lowest wins
    raise_vec = (64'd1 << 9) | (64'd1 << 5); boundary = 1; cur_pc = 17'h100; rd_sel = 0;
    step(); idle();
    check(cur_seq == 5, "R2 lowest runnable", cur_seq, 5);
    check(rd_data == 18'h00100, "R7 saved pc", rd_data, 18'h100);

    // R4 raise beats lower in same cycle
    raise_vec = 64'd1 << 3; lower_vec = 64'd1 << 3; step(); idle();
    boundary = 1; step(); idle();
    check(cur_seq == 3, "R4 raise wins", cur_seq, 3);

    // R3 hold blocks, dismiss with hold ignored
    raise_vec = 64'd1 << 1; boundary = 1; hold = 1; dismiss = 1; step(); idle();
    check(cur_seq == 3, "R3 hold keeps", cur_seq, 3);
    lower_vec = 64'd1 << 1; step(); idle();
    boundary = 1; step(); idle();
    check(cur_seq == 3, "R3 dismiss under hold ignored", cur_seq, 3);

    // R5 dismiss with nothing else runnable
    lower_vec = '1; step(); idle();
    raise_vec = 64'd1 << 7; step(); idle();
    boundary = 1; step(); idle();
    lower_vec = '1; step(); idle();
    boundary = 1; dismiss = 1; step(); idle();
    check(cur_seq == 7, "R5 stays selected", cur_seq, 7);
    raise_vec = 64'd1 << 40; boundary = 1; step(); idle();
    check(cur_seq == 40, "R5 flag was lowered", cur_seq, 40);

    // R6 stall under hold
    raise_vec = 64'd1 << 50; boundary = 1; hold = 1; stall = 1; step(); idle();
    check(cur_seq == 40, "R6 hold keeps during stall", cur_seq, 40);
    boundary = 1; step(); idle();
    check(cur_seq == 50, "R6 stalled flag low", cur_seq, 50);

    // R9 trap on entry
    idx_we = 1; idx_wsel = 20; idx_wdata = {1'b1, 17'h01234}; step(); idle();
    trap_en = 1; raise_vec = 64'd1 << 20; boundary = 1; step(); idle();
    check(trap_req && cur_seq == 20, "R9 trap pulse", {trap_req, cur_seq}, {1'b1, 6'd20});
    check(resume_pc == 17'h01234, "R7 restore", resume_pc, 17'h1234);
    boundary = 1; dismiss = 1; step(); idle();
    check(cur_seq == 34, "R9 trap flag raised", cur_seq, 34);
    trap_en = 0;

    // R11 write colliding with save is dropped
    rd_sel = 34; raise_vec = 64'd1 << 2; boundary = 1; cur_pc = 17'h0777;
    idx_we = 1; idx_wsel = 34; idx_wdata = 18'h0AAAA; step(); idle();
    check(rd_data == 18'h00777, "R11 save wins", rd_data, 18'h777);

    // R10 start
    start = 1; start_pc = 17'h0ABC; raise_vec = 64'd1 << 9; boundary = 1; step(); idle();
    check(cur_seq == 0 && resume_pc == 17'h0ABC, "R10 start", resume_pc, 17'hABC);
    boundary = 1; step(); idle();
    check(cur_seq == 0 && !switch_pulse, "R10 flags cleared", cur_seq, 0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      raise_vec = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      lower_vec = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                & {$urandom, $urandom} & {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) lower_vec = lower_vec | raise_vec;
      boundary  = $urandom_range(0, 1);
      hold      = ($urandom_range(0, 3) == 0);
      dismiss   = ($urandom_range(0, 2) == 0);
      stall     = ($urandom_range(0, 9) == 0);
      start     = ($urandom_range(0, 99) == 0);
      start_pc  = 17'($urandom);
      cur_pc    = 17'($urandom);
      trap_en   = $urandom_range(0, 1);
      idx_we    = ($urandom_range(0, 3) == 0);
      idx_wsel  = ($urandom_range(0, 1) == 0) ? 6'(m_cur) : 6'($urandom);
      idx_wdata = 18'($urandom);
      rd_sel    = 6'($urandom);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule